// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash that accepts JEDEC-style command sequences. The host pulses a start strobe with an opcode, an address and a data word. The block then drives the flash address, data, chip-enable, write-enable and output-enable lines through the required bus writes. Every operation opens with a read-mode reset write. For a word program or an erase, the reset is followed by the unlock and command writes.

After the last command write of a program or erase, the block polls the target location. It can first wait for the ready/busy pin to go high. It compares the returned DQ7 against the bit it expects. When DQ7 mismatches and DQ5 reads 1, the block makes exactly one more read. If that read still mismatches, it issues a read-mode reset and reports failure. Once DQ7 shows completion, the whole word read back must equal the expected array contents: the written data for a program, all ones for an erase.

Command offsets are added to a base address parameter. Offset 0x555 therefore appears on the bus as BASE+0x555.

Top module: `nor_flash_seq`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are low, and flash_we_no, flash_oe_no and flash_ce_no are high.
- R2: Every operation starts with the write 0x00F0 to BASE. Opcode 0 (reset) consists of that write alone and then ends with done and no failure, without any read.
- R3: Opcode 1 (program) continues with these writes: 0x00AA to BASE+0x555, 0x0055 to BASE+0x2AA, 0x00A0 to BASE+0x555, and then the data word to the host address.
- R4: Opcode 2 (sector erase) continues with these writes: 0x00AA to BASE+0x555, 0x0055 to BASE+0x2AA, 0x0080 to BASE+0x555, 0x00AA to BASE+0x555, 0x0055 to BASE+0x2AA, and 0x0030 to the host address.
- R5: Opcode 3 (chip erase) issues the same six writes as R4, except that the last write is 0x0010 to BASE+0x555. Polling then reads BASE.
- R6: Each write holds flash_we_no low for exactly WE_CYC cycles. During that pulse, address and data stay stable, flash_dq_oe_o is high and flash_oe_no is high.
- R7: After each write, flash_we_no and flash_oe_no both stay high for at least REC_CYC cycles before the next bus access.
- R8: A poll read whose DQ7 (bit 7) equals the expected bit ends the operation. The expected bit is bit 7 of the data for a program and 1 for an erase. The operation passes if the full word equals the expected word, and otherwise it fails.
- R9: A poll read with a DQ7 mismatch and DQ5 (bit 5) at 0 is followed by another poll read.
- R10: A poll read with a DQ7 mismatch and DQ5 at 1 causes exactly one further read. If that read matches, the operation passes.
- R11: If that further read also mismatches, the block writes 0x00F0 to BASE and then raises done_o together with fail_o.
- R12: With USE_RDY set, no poll read starts while flash_rdy_i is low.
- R13: busy_o is high from the cycle after an accepted start through the done cycle. done_o is a one-cycle pulse. A start_i pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 2 | 0 reset, 1 program, 2 sector erase, 3 chip erase |
| addr_i | input | AW | Target address in the host map |
| wdata_i | input | 16 | Word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Failure flag, valid with done_o |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | 16 | Data driven toward the flash |
| flash_dq_oe_o | output | 1 | Enable for the data drivers |
| flash_dq_i | input | 16 | Data read from the flash |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_rdy_i | input | 1 | Ready/busy pin, high when ready |

## Verification
The bench models the flash's status reads. It toggles DQ6 and inverts DQ7 for a chosen number of reads, then returns a chosen array word. It also holds the ready pin low for a while after the final command.

The bench targets four kinds of design fault:
- A sequencer that skips the DQ5 re-read would fail an operation that completes on the second look.
- A sequencer that re-reads forever would never report the stuck case.
- A sequencer that trusts DQ7 alone would pass a word with corrupted low bits.
- A sequencer that forgets the closing reset would leave the write queue short.

The bench also fires a second start in the middle of an operation, and checks the recovery gap and the write pulse width on every bus write.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    OP_RST  = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    V_PASS,
    V_POLL,
    V_RECHK,
    V_FAIL
  } verdict_e;

  localparam logic [15:0] D_RDMODE = 16'h00F0;
  localparam logic [15:0] D_UNL_A  = 16'h00AA;
  localparam logic [15:0] D_UNL_B  = 16'h0055;
  localparam logic [15:0] D_PGM    = 16'h00A0;
  localparam logic [15:0] D_ERS    = 16'h0080;
  localparam logic [15:0] D_CHIP   = 16'h0010;
  localparam logic [15:0] D_SECT   = 16'h0030;
  localparam logic [15:0] D_ERASED = 16'hFFFF;

  localparam int unsigned OFS_A = 32'h555;
  localparam int unsigned OFS_B = 32'h2AA;

  // index of final command write, step 0 is the read-mode reset
  function automatic logic [2:0] last_step(op_e op);
    case (op)
      OP_RST:  return 3'd0;
      OP_PROG: return 3'd4;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/nor_seq_cmd_gen.sv
module nor_seq_cmd_gen
  import nor_seq_pkg::*;
#(
  parameter int unsigned AW   = 20,
  parameter int unsigned BASE = 32'h0004_0000
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [15:0]   tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   data_o,
  output logic          last_o
);
  localparam logic [AW-1:0] A_BASE = AW'(BASE);
  localparam logic [AW-1:0] A_UA   = AW'(BASE + OFS_A);
  localparam logic [AW-1:0] A_UB   = AW'(BASE + OFS_B);

  logic is_prog;
  assign is_prog = (op_i == OP_PROG);

  always_comb begin
    addr_o = A_BASE;
    data_o = D_RDMODE;
    case (step_i)
      3'd1: begin addr_o = A_UA; data_o = D_UNL_A; end
      3'd2: begin addr_o = A_UB; data_o = D_UNL_B; end
      3'd3: begin addr_o = A_UA; data_o = is_prog ? D_PGM : D_ERS; end
      3'd4: begin
        addr_o = is_prog ? tgt_addr_i : A_UA;
        data_o = is_prog ? tgt_data_i : D_UNL_A;
      end
      3'd5: begin addr_o = A_UB; data_o = D_UNL_B; end
      3'd6: begin
        addr_o = (op_i == OP_CHIP) ? A_UA : tgt_addr_i;
        data_o = (op_i == OP_CHIP) ? D_CHIP : D_SECT;
      end
      default: ;
    endcase
  end

  assign last_o = (step_i == last_step(op_i));
endmodule

// File: rtl/nor_seq_judge.sv
module nor_seq_judge
  import nor_seq_pkg::*;
(
  input  logic [15:0] rd_i,
  input  logic [15:0] exp_i,
  input  logic        rechk_i,
  output verdict_e    verdict_o
);
  always_comb begin
    if (rd_i[7] == exp_i[7])
      verdict_o = (rd_i == exp_i) ? V_PASS : V_FAIL;
    else if (rechk_i)
      verdict_o = V_FAIL;
    else if (rd_i[5])
      verdict_o = V_RECHK;
    else
      verdict_o = V_POLL;
  end
endmodule

// File: rtl/nor_seq_bus.sv
module nor_seq_bus #(
  parameter int unsigned AW      = 20,
  parameter int unsigned DW      = 16,
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned REC_CYC = 13,
  parameter int unsigned RD_CYC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe_o,
  input  logic [DW-1:0] bus_dq_i,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no
);
  localparam int unsigned M1   = (WE_CYC > REC_CYC) ? WE_CYC : REC_CYC;
  localparam int unsigned MAXC = (M1 > RD_CYC) ? M1 : RD_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {B_IDLE, B_WE, B_GAP, B_OE, B_REST} bst_e;

  bst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;

  logic we_end, gap_end, oe_end;
  assign we_end  = (cnt_q == CW'(WE_CYC - 1));
  assign gap_end = (cnt_q == CW'(REC_CYC - 1));
  assign oe_end  = (cnt_q == CW'(RD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        B_IDLE: begin
          cnt_q <= '0;
          if (wr_req_i) begin
            addr_q <= addr_i;
            data_q <= data_i;
            st_q   <= B_WE;
          end else if (rd_req_i) begin
            addr_q <= addr_i;
            st_q   <= B_OE;
          end
        end
        B_WE: begin
          if (we_end) begin
            cnt_q <= '0;
            st_q  <= B_GAP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        B_GAP: begin
          if (gap_end) st_q <= B_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        B_OE: begin
          if (oe_end) begin
            rd_q <= bus_dq_i;
            st_q <= B_REST;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign ack_o       = (st_q == B_GAP && gap_end) || (st_q == B_REST);
  assign rd_data_o   = rd_q;
  assign bus_addr_o  = addr_q;
  assign bus_dq_o    = data_q;
  assign bus_dq_oe_o = (st_q == B_WE) || (st_q == B_GAP);
  assign we_no       = (st_q != B_WE);
  assign oe_no       = (st_q != B_OE);
  assign ce_no       = (st_q == B_IDLE);
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_seq_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned BASE    = 32'h0004_0000,
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned REC_CYC = 13,
  parameter int unsigned RD_CYC  = 2,
  parameter bit          USE_RDY = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [15:0]   flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [15:0]   flash_dq_i,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no,
  input  logic          flash_rdy_i
);
  localparam logic [AW-1:0] A_BASE = AW'(BASE);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_READ, S_ERR, S_FIN} st_e;

  st_e           st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [2:0]    step_q;
  logic          rechk_q, fail_q;

  logic [AW-1:0] gen_addr, req_addr;
  logic [15:0]   gen_data, req_data, rd_data, exp_word;
  logic          gen_last, ack, wr_req, rd_req;
  verdict_e      verdict;

  nor_seq_cmd_gen #(.AW(AW), .BASE(BASE)) u_cmd (
    .op_i(op_q), .step_i(step_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .addr_o(gen_addr), .data_o(gen_data), .last_o(gen_last)
  );

  // program expects the written word, erases expect all ones
  assign exp_word = (op_q == OP_PROG) ? data_q : D_ERASED;

  nor_seq_judge u_judge (
    .rd_i(rd_data), .exp_i(exp_word), .rechk_i(rechk_q), .verdict_o(verdict)
  );

  assign wr_req = (st_q == S_CMD) || (st_q == S_ERR);
  assign rd_req = (st_q == S_READ);

  always_comb begin
    req_addr = gen_addr;
    req_data = gen_data;
    if (st_q == S_ERR) begin
      req_addr = A_BASE;
      req_data = D_RDMODE;
    end else if (st_q == S_READ) begin
      req_addr = (op_q == OP_CHIP) ? A_BASE : addr_q;
    end
  end

  nor_seq_bus #(
    .AW(AW), .DW(16), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_req_i(wr_req), .rd_req_i(rd_req),
    .addr_i(req_addr), .data_i(req_data),
    .ack_o(ack), .rd_data_o(rd_data),
    .bus_addr_o(flash_addr_o), .bus_dq_o(flash_dq_o), .bus_dq_oe_o(flash_dq_oe_o),
    .bus_dq_i(flash_dq_i),
    .ce_no(flash_ce_no), .we_no(flash_we_no), .oe_no(flash_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_RST;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      rechk_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          op_q    <= op_e'(op_i);
          addr_q  <= addr_i;
          data_q  <= wdata_i;
          step_q  <= '0;
          rechk_q <= 1'b0;
          fail_q  <= 1'b0;
          st_q    <= S_CMD;
        end
        S_CMD: if (ack) begin
          if (!gen_last) step_q <= step_q + 3'd1;
          else if (op_q == OP_RST) st_q <= S_FIN;
          else st_q <= S_WAIT;
        end
        S_WAIT: if (!USE_RDY || flash_rdy_i) st_q <= S_READ;
        S_READ: if (ack) begin
          case (verdict)
            V_PASS:  st_q <= S_FIN;
            V_RECHK: rechk_q <= 1'b1;
            V_POLL:  st_q <= S_WAIT;
            default: begin
              fail_q <= 1'b1;
              st_q   <= S_ERR;
            end
          endcase
        end
        S_ERR: if (ack) st_q <= S_FIN;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);
  assign fail_o = done_o && fail_q;
endmodule

module nor_flash_seq_chk #(
  parameter int unsigned AW      = 20,
  parameter bit          USE_RDY = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] flash_addr_o,
  input logic [15:0]   flash_dq_o,
  input logic          flash_dq_oe_o,
  input logic          flash_we_no,
  input logic          flash_oe_no,
  input logic          flash_rdy_i
);
  // R6
  we_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));
  // R6
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));
  // R6
  we_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> flash_dq_oe_o);
  // R7
  we_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |=> (flash_we_no && flash_oe_no));
  // R11
  fail_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R13
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (flash_we_no && flash_oe_no));
  // R12
  rdy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (USE_RDY && $fell(flash_oe_no)) |-> flash_rdy_i);
endmodule

bind nor_flash_seq nor_flash_seq_chk #(.AW(AW), .USE_RDY(USE_RDY)) u_chk (.*);

// File: tb/nor_flash_seq_tb.sv
module nor_flash_seq_tb;
  localparam int unsigned AW = 20;
  localparam int unsigned BASE = 32'h0004_0000;
  localparam int WE_CYC = 2;
  localparam int REC_CYC = 13;
  localparam logic [AW-1:0] B = AW'(BASE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done, fail, dq_oe, ce_n, we_n, oe_n;
  logic [AW-1:0] f_addr;
  logic [15:0] f_dq_o;
  logic [15:0] f_dq_i = 16'hFFFF;
  logic rdy = 1'b1;

  always #5 clk = ~clk;

  nor_flash_seq #(.AW(AW), .BASE(BASE), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_oe_o(dq_oe), .flash_dq_i(f_dq_i),
    .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n), .flash_rdy_i(rdy)
  );

  int tests = 0, errors = 0;
  logic [AW+15:0] expq[$];

  // flash model configuration
  int  cfg_busy = 0;
  bit  cfg_to = 0, cfg_stuck = 0;
  int  cfg_rdy = 0;
  logic [15:0] cfg_word = '0;
  logic [15:0] exp_word = '0;
  int  n_cmd = 1;

  // monitor state
  int  wr_idx = 0, reads = 0, busy_left = 0, rdy_cnt = 0, we_low = 0, since_wr = 1000;
  bit  tog = 0, prev_we = 1, prev_oe = 1;
  logic [AW-1:0] rd_addr = '0, cap_a = '0;
  logic [15:0] cap_d = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      // R6 no overlap of write and read strobes
      if (!we_n && !oe_n) chk(0, "R6", "we/oe overlap", 0, 1);
      if (!we_n) begin
        if (!prev_we) begin
          chk(f_addr == cap_a && f_dq_o == cap_d, "R6", "addr/data stable", f_addr, cap_a);
        end else begin
          // R7 gap before this write
          chk(since_wr >= REC_CYC, "R7", "gap before write", since_wr, REC_CYC);
        end
        chk(dq_oe == 1'b1, "R6", "dq drive", dq_oe, 1);
        cap_a = f_addr;
        cap_d = f_dq_o;
        we_low++;
      end
      if (!prev_we && we_n) begin
        chk(we_low == WE_CYC, "R6", "we width", we_low, WE_CYC);
        we_low = 0;
        since_wr = 1;
        if (expq.size() == 0) chk(0, "R2", "unexpected write", {cap_a, cap_d}, 0);
        else begin
          logic [AW+15:0] e;
          e = expq.pop_front();
          chk({cap_a, cap_d} == e, "R3", "write addr/data", {cap_a, cap_d}, e);
        end
        wr_idx++;
        if (wr_idx == n_cmd) begin
          busy_left = cfg_busy;
          rdy_cnt = cfg_rdy;
        end
      end else if (we_n && oe_n) since_wr++;
      if (prev_oe && !oe_n) begin
        reads++;
        rd_addr = f_addr;
        chk(since_wr >= REC_CYC, "R7", "gap before read", since_wr, REC_CYC);
        // R12
        chk(rdy == 1'b1, "R12", "read while not ready", rdy, 1);
      end
      if (!prev_oe && oe_n) begin
        if (busy_left > 0 && !cfg_stuck) busy_left--;
        tog = ~tog;
      end
      if (rdy_cnt > 0) rdy_cnt--;
      rdy = (rdy_cnt == 0);
      if (cfg_stuck || busy_left > 0)
        f_dq_i = {8'h00, ~exp_word[7], tog, cfg_to, 5'b0};
      else f_dq_i = cfg_word;
      prev_we = we_n;
      prev_oe = oe_n;
    end
  end

  task automatic push(logic [AW-1:0] a, logic [15:0] d);
    expq.push_back({a, d});
  endtask

  task automatic plan(logic [1:0] o, logic [AW-1:0] a, logic [15:0] d);
    push(B, 16'h00F0);
    n_cmd = 1;
    if (o != 2'd0) begin
      push(B + 'h555, 16'h00AA);
      push(B + 'h2AA, 16'h0055);
      if (o == 2'd1) begin
        push(B + 'h555, 16'h00A0);
        push(a, d);
        n_cmd = 5;
        exp_word = d;
      end else begin
        push(B + 'h555, 16'h0080);
        push(B + 'h555, 16'h00AA);
        push(B + 'h2AA, 16'h0055);
        if (o == 2'd3) push(B + 'h555, 16'h0010);
        else push(a, 16'h0030);
        n_cmd = 7;
        exp_word = 16'hFFFF;
      end
    end
  endtask

  // run one op; stray_op>=0 fires a second start mid-operation
  task automatic run(string req, logic [1:0] o, logic [AW-1:0] a, logic [15:0] d,
                     bit exp_fail, int exp_reads, logic [AW-1:0] exp_ra, int stray_op);
    plan(o, a, d);
    if (exp_fail) push(B, 16'h00F0);
    wr_idx = 0;
    reads = 0;
    @(negedge clk);
    op = o; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R13", "busy after start", busy, 1);
    if (stray_op >= 0) begin
      repeat (5) @(negedge clk);
      op = 2'(stray_op); addr = a + 'h10; wdata = ~d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b1, "R13", "busy during done", busy, 1);
    chk(fail == exp_fail, exp_fail ? "R11" : "R8", {req, " fail flag"}, fail, exp_fail);
    chk(expq.size() == 0, "R2", {req, " writes left"}, expq.size(), 0);
    chk(reads == exp_reads, req, "poll reads", reads, exp_reads);
    if (exp_reads > 0) chk(rd_addr == exp_ra, req, "poll address", rd_addr, exp_ra);
    expq.delete();
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R13", "done pulse ends", {done, busy}, 0);
  endtask

  initial begin : wdog
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    tests++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && fail == 0, "R1", "status at reset", {busy, done, fail}, 0);
    chk(we_n && oe_n && ce_n, "R1", "strobes at reset", {we_n, oe_n, ce_n}, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reset opcode
    run("R2", 2'd0, B + 'h100, 16'h0, 0, 0, B, -1);

    // R3 R9 program, bit7 = 0, three busy reads
    cfg_busy = 3; cfg_to = 0; cfg_stuck = 0; cfg_rdy = 40; cfg_word = 16'h1234;
    run("R9", 2'd1, B + 'h1230, 16'h1234, 0, 4, B + 'h1230, -1);

    // R3 R8 program, bit7 = 1, immediate completion
    cfg_busy = 0; cfg_rdy = 0; cfg_word = 16'h00C5;
    run("R8", 2'd1, B + 'h0007, 16'h00C5, 0, 1, B + 'h0007, -1);

    // R4 R12 sector erase, ready held low
    cfg_busy = 2; cfg_rdy = 60; cfg_word = 16'hFFFF;
    run("R4", 2'd2, B + 'h8000, 16'h0, 0, 3, B + 'h8000, -1);

    // R5 chip erase polled at base
    cfg_busy = 1; cfg_rdy = 20; cfg_word = 16'hFFFF;
    run("R5", 2'd3, B + 'h4444, 16'h0, 0, 2, B, -1);

    // R10 timeout flag then completion on the re-read
    cfg_busy = 1; cfg_to = 1; cfg_rdy = 0; cfg_word = 16'h5A5A;
    run("R10", 2'd1, B + 'h0300, 16'h5A5A, 0, 2, B + 'h0300, -1);

    // R11 stuck with timeout flag, fail plus reset write
    cfg_busy = 0; cfg_to = 1; cfg_stuck = 1; cfg_word = 16'h0000;
    run("R11", 2'd1, B + 'h0301, 16'h0081, 1, 2, B + 'h0301, -1);

    // R8 DQ7 matches but a low bit is wrong
    cfg_stuck = 0; cfg_to = 0; cfg_busy = 1; cfg_word = 16'h00F1;
    run("R8", 2'd1, B + 'h0302, 16'h00F0, 1, 2, B + 'h0302, -1);

    // R13 second start while busy is ignored
    cfg_busy = 2; cfg_word = 16'h7E00; cfg_rdy = 10;
    run("R13", 2'd1, B + 'h0400, 16'h7E00, 0, 3, B + 'h0400, 3);

    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end
endmodule